// File: doc/BRIEF.md
# Three-Level Compressibility Predictor

This block guesses, before a memory line is fetched, whether that line is stored in compressed form. A read controller uses the guess to choose between reading only the sub-rank that can hold a compressed line and reading both sub-ranks in parallel. Once the line has been fetched and its real state is known, the controller reports the outcome back to the block.

The guess draws on three linked tables. The first is a small global table of 2-bit saturating confidence counters. The second is a page-indexed table of 2-bit counters. The third is a page-indexed bit vector with one bit per line of the page. Lines are 64 bytes and pages are 4 KB, so each page has 64 lines.

The caller passes a line address, meaning a byte address with its 6 offset bits removed. Bits [5:0] give the line within the page. Bits [9:6] give the page-table slot, taken as the low bits of the page number. Page slots are direct-mapped and carry no tag. The lookup port and the update port are independent and may both be active in the same cycle.

Top module: `compress_predictor`

## Requirements
- R1: After reset all counters and line bits are zero, so every lookup returns `pred_comp`=0 and `pred_from_line`=0.
- R2: `pred_valid` is high exactly one cycle after a cycle with `lk_valid` high, and low otherwise. A lookup sees the effect of every update accepted in an earlier cycle. It does not see an update accepted in the same cycle.
- R3: Address bits [7:6] (the low two page-slot bits) select one of four global counters. On an update whose `upd_pred` equals `upd_actual`, that counter increments, saturating at 3.
- R4: On an update whose `upd_pred` differs from `upd_actual`, the selected global counter becomes 0.
- R5: Address bits [9:6] select one of 16 page counters. On a correct update that page counter increments, saturating at 3.
- R6: On a wrong update, the page counter takes the value the selected global counter held before that update.
- R7: Address bits [5:0] select the line bit within the page's vector. An update sets that bit when `upd_pred` and `upd_actual` are both 1, and clears it in every other case.
- R8: If the page counter held 2 or more before an update, that update also sets the bits of lines index-1 and index+1. There is no wrap: line 0 has no lower neighbour and line 63 has no upper neighbour.
- R9: If the page counter is 2 or more, the prediction is the line bit and `pred_from_line`=1. Otherwise the prediction is (global counter >= 2) and `pred_from_line`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 10 | Lookup line address (slot in [9:6], line in [5:0]) |
| upd_valid | input | 1 | Outcome report |
| upd_addr | input | 10 | Line address of the reported access |
| upd_pred | input | 1 | Prediction that was used for the access (1 = compressed) |
| upd_actual | input | 1 | Whether the line turned out compressed |
| pred_valid | output | 1 | Prediction result valid |
| pred_comp | output | 1 | Predicted compressed |
| pred_from_line | output | 1 | Prediction came from the line bit rather than the global counter |

## Verification
Prediction outputs are registered, so a lookup driven before edge N is due on the ports just after edge N. The bench drives each request on a falling edge and samples the result on the next falling edge. Table writes land on the edge that accepts the update, so the bench applies each update to its arithmetic model only after the update's edge. It computes the expected value of a same-cycle lookup from the model state before that update. Neighbour setting and line-bit clearing are observed one lookup later, through the line bits of the affected lines.

// File: rtl/cp_pkg.sv
package cp_pkg;
  localparam int unsigned CNT_W = 2;
  localparam int unsigned CONF_THR = 2;
  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t cnt_bump(input cnt_t c);
    return (c == {CNT_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  function automatic logic cnt_conf(input cnt_t c);
    return c >= cnt_t'(CONF_THR);
  endfunction
endpackage

// File: rtl/cp_global_table.sv
module cp_global_table
  import cp_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  output cnt_t          rd_cnt,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic          upd_correct,
  output cnt_t          upd_cnt
);
  cnt_t cnt_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) cnt_q[g] <= '0;
      else if (upd_en && upd_idx == IW'(g))
        cnt_q[g] <= upd_correct ? cnt_bump(cnt_q[g]) : '0;
    end
  end

  assign rd_cnt  = cnt_q[rd_idx];
  assign upd_cnt = cnt_q[upd_idx];

  // R4: a wrong outcome empties the selected counter
  a_r4_wrong_clears: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_correct) |=> (cnt_q[$past(upd_idx)] == '0));
  // R3: a correct outcome never lowers the counter
  a_r3_correct_no_drop: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_correct) |=> (cnt_q[$past(upd_idx)] >= $past(upd_cnt)));
endmodule

// File: rtl/cp_page_table.sv
module cp_page_table
  import cp_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  output cnt_t          rd_cnt,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic          upd_correct,
  input  cnt_t          upd_global_cnt,
  output cnt_t          upd_cnt
);
  cnt_t cnt_q [ENTRIES];

  for (genvar p = 0; p < ENTRIES; p++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) cnt_q[p] <= '0;
      else if (upd_en && upd_idx == IW'(p))
        cnt_q[p] <= upd_correct ? cnt_bump(cnt_q[p]) : upd_global_cnt;
    end
  end

  assign rd_cnt  = cnt_q[rd_idx];
  assign upd_cnt = cnt_q[upd_idx];

  // R6: a wrong outcome copies the global counter's prior value
  a_r6_copy_global: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_correct) |=> (cnt_q[$past(upd_idx)] == $past(upd_global_cnt)));
  // R5: a correct outcome never lowers the page counter
  a_r5_correct_no_drop: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_correct) |=> (cnt_q[$past(upd_idx)] >= $past(upd_cnt)));
endmodule

// File: rtl/cp_line_table.sv
module cp_line_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned LINES   = 64,
  localparam int unsigned IW = $clog2(ENTRIES),
  localparam int unsigned LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_idx,
  input  logic [LW-1:0] rd_line,
  output logic          rd_bit,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [LW-1:0] upd_line,
  input  logic          upd_set,
  input  logic          upd_spread
);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

  logic [LINES-1:0] vec_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) vec_q[e] <= '0;
    end else if (upd_en) begin
      vec_q[upd_idx][upd_line] <= upd_set;
      if (upd_spread && upd_line != '0)
        vec_q[upd_idx][upd_line - 1'b1] <= 1'b1;
      if (upd_spread && upd_line != LAST_LINE)
        vec_q[upd_idx][upd_line + 1'b1] <= 1'b1;
    end
  end

  assign rd_bit = vec_q[rd_idx][rd_line];

  // R7: the addressed bit follows the set request
  a_r7_bit_written: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (vec_q[$past(upd_idx)][$past(upd_line)] == $past(upd_set)));
  // R8: lower neighbour is set on a spread update
  a_r8_lower_neighbour: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_spread && upd_line != '0) |=>
      vec_q[$past(upd_idx)][$past(upd_line) - 1'b1]);
  // R8: upper neighbour is set on a spread update
  a_r8_upper_neighbour: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_spread && upd_line != LAST_LINE) |=>
      vec_q[$past(upd_idx)][$past(upd_line) + 1'b1]);
endmodule

// File: rtl/compress_predictor.sv
module compress_predictor
  import cp_pkg::*;
#(
  parameter int unsigned GLOBAL_ENTRIES = 4,
  parameter int unsigned PAGE_ENTRIES   = 16,
  parameter int unsigned LINES_PER_PAGE = 64,
  localparam int unsigned GW = $clog2(GLOBAL_ENTRIES),
  localparam int unsigned PW = $clog2(PAGE_ENTRIES),
  localparam int unsigned LW = $clog2(LINES_PER_PAGE),
  localparam int unsigned AW = PW + LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_addr,
  input  logic          upd_pred,
  input  logic          upd_actual,
  output logic          pred_valid,
  output logic          pred_comp,
  output logic          pred_from_line
);
  logic [LW-1:0] lk_line, up_line;
  logic [PW-1:0] lk_page, up_page;
  logic [GW-1:0] lk_glb, up_glb;
  logic          up_correct;

  assign lk_line = lk_addr[LW-1:0];
  assign lk_page = lk_addr[LW +: PW];
  assign lk_glb  = lk_page[GW-1:0];
  assign up_line = upd_addr[LW-1:0];
  assign up_page = upd_addr[LW +: PW];
  assign up_glb  = up_page[GW-1:0];
  assign up_correct = (upd_pred == upd_actual);

  cnt_t g_rd, g_up, p_rd, p_up;
  logic l_rd;

  cp_global_table #(.ENTRIES(GLOBAL_ENTRIES)) u_glb (
    .clk(clk), .rst(rst),
    .rd_idx(lk_glb), .rd_cnt(g_rd),
    .upd_en(upd_valid), .upd_idx(up_glb), .upd_correct(up_correct),
    .upd_cnt(g_up)
  );

  cp_page_table #(.ENTRIES(PAGE_ENTRIES)) u_page (
    .clk(clk), .rst(rst),
    .rd_idx(lk_page), .rd_cnt(p_rd),
    .upd_en(upd_valid), .upd_idx(up_page), .upd_correct(up_correct),
    .upd_global_cnt(g_up), .upd_cnt(p_up)
  );

  cp_line_table #(.ENTRIES(PAGE_ENTRIES), .LINES(LINES_PER_PAGE)) u_line (
    .clk(clk), .rst(rst),
    .rd_idx(lk_page), .rd_line(lk_line), .rd_bit(l_rd),
    .upd_en(upd_valid), .upd_idx(up_page), .upd_line(up_line),
    .upd_set(upd_pred & upd_actual), .upd_spread(cnt_conf(p_up))
  );

  logic use_line;
  assign use_line = cnt_conf(p_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid     <= 1'b0;
      pred_comp      <= 1'b0;
      pred_from_line <= 1'b0;
    end else begin
      pred_valid     <= lk_valid;
      pred_comp      <= lk_valid & (use_line ? l_rd : cnt_conf(g_rd));
      pred_from_line <= lk_valid & use_line;
    end
  end

  // R2: result is due exactly one cycle after the request
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid);
  // R9: outputs stay quiet without a result
  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |-> (!pred_comp && !pred_from_line));
endmodule

// File: tb/tb_compress_predictor.sv
`timescale 1ns/1ps
module tb_compress_predictor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lk_valid = 1'b0;
  logic [9:0] lk_addr = '0;
  logic       upd_valid = 1'b0;
  logic [9:0] upd_addr = '0;
  logic       upd_pred = 1'b0;
  logic       upd_actual = 1'b0;
  logic       pred_valid, pred_comp, pred_from_line;

  always #4 clk = ~clk;

  compress_predictor dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .upd_valid(upd_valid), .upd_addr(upd_addr),
    .upd_pred(upd_pred), .upd_actual(upd_actual),
    .pred_valid(pred_valid), .pred_comp(pred_comp), .pred_from_line(pred_from_line)
  );

  int checks = 0;
  int errors = 0;
  int gm [4];
  int pm [16];
  logic [63:0] lm [16];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model_pred(int pg, int ln, output int comp, output int src);
    if (pm[pg] >= 2) begin
      src = 1; comp = int'(lm[pg][ln]);
    end else begin
      src = 0; comp = (gm[pg % 4] >= 2) ? 1 : 0;
    end
  endfunction

  function automatic void model_upd(int pg, int ln, int pr, int ac);
    int g_old, p_old;
    g_old = gm[pg % 4];
    p_old = pm[pg];
    if (pr == ac) begin
      gm[pg % 4] = (g_old == 3) ? 3 : g_old + 1;
      pm[pg]     = (p_old == 3) ? 3 : p_old + 1;
    end else begin
      gm[pg % 4] = 0;
      pm[pg]     = g_old;
    end
    lm[pg][ln] = (pr == 1 && ac == 1);
    if (p_old >= 2) begin
      if (ln > 0)  lm[pg][ln-1] = 1'b1;
      if (ln < 63) lm[pg][ln+1] = 1'b1;
    end
  endfunction

  task automatic look(int pg, int ln, string tag);
    int ec, es;
    model_pred(pg, ln, ec, es);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 10'(pg * 64 + ln);
    @(negedge clk);
    lk_valid = 1'b0;
    chk({tag, " valid"}, int'(pred_valid), 1);
    chk({tag, " comp"}, int'(pred_comp), ec);
    chk({tag, " src"}, int'(pred_from_line), es);
  endtask

  task automatic upd(int pg, int ln, int pr, int ac);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = 10'(pg * 64 + ln);
    upd_pred = pr[0]; upd_actual = ac[0];
    @(negedge clk);
    upd_valid = 1'b0;
    model_upd(pg, ln, pr, ac);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ec, es, mp, pr, ac, pg, ln;
    for (int i = 0; i < 16; i++) begin pm[i] = 0; lm[i] = '0; end
    for (int i = 0; i < 4; i++) gm[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: cleared state on every slot
    for (int p = 0; p < 16; p++) begin
      look(p, 0, "R1");
      look(p, 63, "R1");
    end
    // R2: no result without a request
    @(negedge clk);
    chk("R2 idle", int'(pred_valid), 0);

    // R3: four correct reports on slot 1 saturate global[1] at 3 (wrap would give 0)
    for (int k = 0; k < 4; k++) upd(1, 10, 0, 0);
    look(5, 3, "R3 saturate");
    look(2, 3, "R3 other index");
    // R4: a wrong report on slot 9 clears global[1]
    upd(9, 4, 1, 0);
    look(13, 3, "R4 cleared");

    // R5/R6: build global[0]=3, then a wrong report on slot 8 copies 3 into page 8
    for (int k = 0; k < 3; k++) upd(4, 20, 0, 0);
    upd(8, 30, 0, 1);
    look(8, 30, "R6 copied");
    look(8, 31, "R6 copied");
    // R5: page counter climbs on correct reports on slot 6
    upd(6, 1, 0, 0);
    look(6, 1, "R5 one");
    upd(6, 1, 0, 0);
    look(6, 1, "R5 two");

    // R7: set only when predicted and actually compressed, cleared otherwise
    upd(6, 40, 1, 1);
    look(6, 40, "R7 set");
    upd(6, 40, 0, 1);
    look(6, 40, "R7 clear");

    // R8: neighbours at the page edges without wrap
    upd(6, 0, 1, 1);
    look(6, 1, "R8 upper");
    look(6, 63, "R8 no wrap low");
    upd(8, 63, 1, 1);
    look(8, 62, "R8 lower");
    look(8, 0, "R8 no wrap high");

    // R2: same-cycle lookup sees the old state
    model_pred(3, 7, ec, es);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 10'(3 * 64 + 7);
    upd_valid = 1'b1; upd_addr = 10'(3 * 64 + 7); upd_pred = 1'b0; upd_actual = 1'b0;
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    chk("R2 same cycle comp", int'(pred_comp), ec);
    chk("R2 same cycle src", int'(pred_from_line), es);
    model_upd(3, 7, 0, 0);
    look(3, 7, "R2 after update");

    // R9: deterministic sweep across slots and lines
    for (int i = 0; i < 1500; i++) begin
      pg = (i * 7 + 3) % 16;
      ln = (i * 13 + i / 5) % 64;
      model_pred(pg, ln, mp, es);
      pr = (i % 9 == 0) ? 1 - mp : mp;
      ac = ((i * 11) % 5 != 0) ? 1 : 0;
      upd(pg, ln, pr, ac);
      look(pg, ln, "R9 sweep");
      look(pg, (ln + 1) % 64, "R9 sweep neighbour");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule